// File: doc/BRIEF.md
# Platform Error Aggregator

This block collects error and fault indications from several I/O domains of a server board: parity and system errors on the host PCI and PCI-X buses and on a riser PCI-X bus, two non-fatal alert lines, and three power faults (supply power-good loss, regulator fault, CPU thermal trip). Every input is synchronised and edge-detected, and each asserting edge sets a sticky status bit. Software reads and clears these bits through a small byte-wide register port. The port stands in for the transactions of an I2C-style management bus.

From the status the block derives four outputs. The first is a one-cycle fatal-error broadcast request on any host-bus parity error. The second is an optional bus reset that goes with that request when a board strap allows it. The third is a level interrupt for enabled status groups. The fourth is an active-low fault link to the management controller. A write to the SMI control register arms a timer, and the timer produces a single SMI pulse after a parameterised delay. The default delay is 100 ms at 200 MHz.

Top module: `err_hub`

## Requirements
- R1: A rising edge on `pci_perr_i` or `pcix_perr_i` produces exactly one one-cycle pulse on `fatal_req_o`. SERR inputs, riser inputs, alerts and power faults never pulse `fatal_req_o`.
- R2: `bus_rst_o` pulses in the same cycle as `fatal_req_o` only when `rst_on_fatal_i` is high. When the strap is low it stays low.
- R3: Host bus status is at address 0x12, with bit0 PCI PERR, bit1 PCI SERR, bit2 PCI-X PERR and bit3 PCI-X SERR. Riser status is at address 0x15, with bit0 riser PERR and bit1 riser SERR. In both registers, writing a 1 to a bit clears it.
- R4: Alert status is at address 0x10, with bit0 main alert and bit1 riser alert. A read returns the current value and clears both bits. An alert edge that lands in the same cycle as the read stays set. Writes to 0x10 have no effect.
- R5: Power status is at address 0x11, with bit0 supply power-good fault, bit1 regulator fault and bit2 CPU thermal trip. Writing a 1 to a bit clears it.
- R6: Each input passes through two synchroniser flops. A status bit is set only on the input's rising edge. An input held high after its bit has been cleared does not set the bit again.
- R7: `irq_o` is high while any status bit of an enabled group is set, and low once none is. The enables are in the mask register at 0x13: bit0 alert, bit1 power, bit2 host bus, bit3 riser. The mask resets to 0x0F.
- R8: `fault_link_n_o` is low while any power status bit is set, and high otherwise.
- R9: The SMI control register is at 0x14. It reads back the last byte written and resets to 0x01. A write with bit0 = 0 gives one one-cycle `smi_o` pulse exactly `SMI_DELAY_CYC` clock cycles after the write edge. A write with bit0 = 1 starts nothing.
- R10: A write with bit0 = 0 while a delay is pending restarts the delay from the new write. Only one pulse results.
- R11: After reset, all status reads return 0, `irq_o`, `fatal_req_o`, `bus_rst_o` and `smi_o` are 0, and `fault_link_n_o` is 1. Reads of unmapped addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pci_perr_i | input | 1 | Host PCI parity error, asynchronous |
| pci_serr_i | input | 1 | Host PCI system error |
| pcix_perr_i | input | 1 | Host PCI-X parity error |
| pcix_serr_i | input | 1 | Host PCI-X system error |
| riser_perr_i | input | 1 | Riser PCI-X parity error |
| riser_serr_i | input | 1 | Riser PCI-X system error |
| alert_main_i | input | 1 | Non-fatal alert from main bridge |
| alert_riser_i | input | 1 | Non-fatal alert from riser bridge |
| psu_fault_i | input | 1 | Supply power-good fault |
| vrd_fault_i | input | 1 | Voltage regulator fault |
| thermtrip_i | input | 1 | CPU thermal trip |
| rst_on_fatal_i | input | 1 | Strap: issue bus reset with fatal request |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_addr_i | input | 8 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data, valid the cycle after the read strobe, held until the next read |
| fatal_req_o | output | 1 | Fatal-error broadcast request pulse |
| bus_rst_o | output | 1 | Bus reset pulse on fatal error |
| irq_o | output | 1 | Level interrupt |
| fault_link_n_o | output | 1 | Active-low fault link to management controller |
| smi_o | output | 1 | Delayed SMI pulse |

## Verification
The bench goes after five corner cases.

- **Input held high after a clear.** A design that sets status on level instead of edge would set the bit again at once, and would also leave the interrupt and the fault link stuck active.
- **Alert edge in the same cycle as the alert read.** This is timed to the exact cycle. A design that lets the clear win would lose that event.
- **SMI re-arm while pending.** An off-by-one counter would miss the exact delay. A design that does not restart would fire early or twice.
- **Error classes that must not raise a fatal request.** The bench checks that SERR, riser and power inputs leave `fatal_req_o` low.
- **Strap setting.** The bench checks that `bus_rst_o` follows the strap.

Random read, write-1-to-clear and mask traffic then checks `irq_o` against a model of all four groups.

// File: rtl/err_hub_pkg.sv
package err_hub_pkg;

  localparam int SRC_W = 11;

  localparam int IX_PCI_PERR   = 0;
  localparam int IX_PCI_SERR   = 1;
  localparam int IX_PCIX_PERR  = 2;
  localparam int IX_PCIX_SERR  = 3;
  localparam int IX_RSR_PERR   = 4;
  localparam int IX_RSR_SERR   = 5;
  localparam int IX_ALERT_MAIN = 6;
  localparam int IX_ALERT_RSR  = 7;
  localparam int IX_PSU        = 8;
  localparam int IX_VRD        = 9;
  localparam int IX_THERM      = 10;

  localparam logic [7:0] A_ALERT = 8'h10;
  localparam logic [7:0] A_PWR   = 8'h11;
  localparam logic [7:0] A_HOST  = 8'h12;
  localparam logic [7:0] A_MASK  = 8'h13;
  localparam logic [7:0] A_SMI   = 8'h14;
  localparam logic [7:0] A_RISER = 8'h15;

  localparam int GRP_N = 4;

  typedef struct packed {
    logic [1:0] alert;
    logic [2:0] pwr;
    logic [3:0] host;
    logic [1:0] riser;
  } stat_t;

endpackage

// File: rtl/err_hub_sync.sv
module err_hub_sync #(
  parameter int W      = 11,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] rise_o
);

  genvar g;
  generate
    for (g = 0; g < W; g++) begin : g_bit
      logic [STAGES:0] sh;
      always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], async_i[g]};
      end
      assign rise_o[g] = sh[STAGES-1] & ~sh[STAGES];
    end
  endgenerate

endmodule

// File: rtl/err_hub_regs.sv
module err_hub_regs
  import err_hub_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [SRC_W-1:0]  rise_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output stat_t             stat_o,
  output logic [GRP_N-1:0]  mask_o,
  output logic              smi_arm_o
);

  localparam logic [DATA_W-1:0] CTL_RST = DATA_W'(1);

  stat_t             stat_q, stat_d;
  logic [GRP_N-1:0]  mask_q;
  logic [DATA_W-1:0] ctl_q;
  logic [DATA_W-1:0] rd_mux;

  logic wr_pwr, wr_host, wr_rsr, wr_mask, wr_smi, rd_alert;
  assign wr_pwr   = wr_i && (addr_i == ADDR_W'(A_PWR));
  assign wr_host  = wr_i && (addr_i == ADDR_W'(A_HOST));
  assign wr_rsr   = wr_i && (addr_i == ADDR_W'(A_RISER));
  assign wr_mask  = wr_i && (addr_i == ADDR_W'(A_MASK));
  assign wr_smi   = wr_i && (addr_i == ADDR_W'(A_SMI));
  assign rd_alert = rd_i && (addr_i == ADDR_W'(A_ALERT));

  // clears first, new edges last so an event in a clearing cycle survives
  always_comb begin
    stat_d = stat_q;
    if (rd_alert) stat_d.alert = '0;
    if (wr_pwr)   stat_d.pwr   = stat_q.pwr   & ~wdata_i[2:0];
    if (wr_host)  stat_d.host  = stat_q.host  & ~wdata_i[3:0];
    if (wr_rsr)   stat_d.riser = stat_q.riser & ~wdata_i[1:0];
    stat_d.alert = stat_d.alert | {rise_i[IX_ALERT_RSR], rise_i[IX_ALERT_MAIN]};
    stat_d.pwr   = stat_d.pwr   | {rise_i[IX_THERM], rise_i[IX_VRD], rise_i[IX_PSU]};
    stat_d.host  = stat_d.host  | {rise_i[IX_PCIX_SERR], rise_i[IX_PCIX_PERR],
                                   rise_i[IX_PCI_SERR], rise_i[IX_PCI_PERR]};
    stat_d.riser = stat_d.riser | {rise_i[IX_RSR_SERR], rise_i[IX_RSR_PERR]};
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      ADDR_W'(A_ALERT): rd_mux[1:0]       = stat_q.alert;
      ADDR_W'(A_PWR):   rd_mux[2:0]       = stat_q.pwr;
      ADDR_W'(A_HOST):  rd_mux[3:0]       = stat_q.host;
      ADDR_W'(A_RISER): rd_mux[1:0]       = stat_q.riser;
      ADDR_W'(A_MASK):  rd_mux[GRP_N-1:0] = mask_q;
      ADDR_W'(A_SMI):   rd_mux            = ctl_q;
      default:          rd_mux            = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q  <= '0;
      mask_q  <= '1;
      ctl_q   <= CTL_RST;
      rdata_o <= '0;
    end else begin
      stat_q <= stat_d;
      if (wr_mask) mask_q  <= wdata_i[GRP_N-1:0];
      if (wr_smi)  ctl_q   <= wdata_i;
      if (rd_i)    rdata_o <= rd_mux;
    end
  end

  assign stat_o    = stat_q;
  assign mask_o    = mask_q;
  assign smi_arm_o = wr_smi && !wdata_i[0];

endmodule

// File: rtl/err_hub_smi.sv
module err_hub_smi #(
  parameter int DELAY_CYC = 20_000_000
) (
  input  logic clk,
  input  logic rst,
  input  logic arm_i,
  output logic smi_o
);

  localparam int CNT_W = $clog2(DELAY_CYC + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      smi_o <= 1'b0;
    end else begin
      smi_o <= 1'b0;
      if (arm_i) begin
        cnt_q <= CNT_W'(DELAY_CYC);
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CNT_W'(1)) smi_o <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/err_hub.sv
module err_hub
  import err_hub_pkg::*;
#(
  parameter int SMI_DELAY_CYC = 20_000_000,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       pci_perr_i,
  input  logic       pci_serr_i,
  input  logic       pcix_perr_i,
  input  logic       pcix_serr_i,
  input  logic       riser_perr_i,
  input  logic       riser_serr_i,
  input  logic       alert_main_i,
  input  logic       alert_riser_i,
  input  logic       psu_fault_i,
  input  logic       vrd_fault_i,
  input  logic       thermtrip_i,
  input  logic       rst_on_fatal_i,
  input  logic       reg_wr_i,
  input  logic       reg_rd_i,
  input  logic [7:0] reg_addr_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  output logic       fatal_req_o,
  output logic       bus_rst_o,
  output logic       irq_o,
  output logic       fault_link_n_o,
  output logic       smi_o
);

  logic [SRC_W-1:0] src;
  logic [SRC_W-1:0] rise;
  stat_t            stat;
  logic [GRP_N-1:0] mask_q;
  logic [GRP_N-1:0] grp_any;
  logic             smi_arm;
  logic             perr_edge;

  assign src[IX_PCI_PERR]   = pci_perr_i;
  assign src[IX_PCI_SERR]   = pci_serr_i;
  assign src[IX_PCIX_PERR]  = pcix_perr_i;
  assign src[IX_PCIX_SERR]  = pcix_serr_i;
  assign src[IX_RSR_PERR]   = riser_perr_i;
  assign src[IX_RSR_SERR]   = riser_serr_i;
  assign src[IX_ALERT_MAIN] = alert_main_i;
  assign src[IX_ALERT_RSR]  = alert_riser_i;
  assign src[IX_PSU]        = psu_fault_i;
  assign src[IX_VRD]        = vrd_fault_i;
  assign src[IX_THERM]      = thermtrip_i;

  err_hub_sync #(.W(SRC_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .async_i(src), .rise_o(rise)
  );

  err_hub_regs #(.ADDR_W(8), .DATA_W(8)) u_regs (
    .clk(clk), .rst(rst), .rise_i(rise),
    .wr_i(reg_wr_i), .rd_i(reg_rd_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .rdata_o(reg_rdata_o), .stat_o(stat), .mask_o(mask_q), .smi_arm_o(smi_arm)
  );

  err_hub_smi #(.DELAY_CYC(SMI_DELAY_CYC)) u_smi (
    .clk(clk), .rst(rst), .arm_i(smi_arm), .smi_o(smi_o)
  );

  assign grp_any   = {|stat.riser, |stat.host, |stat.pwr, |stat.alert};
  assign perr_edge = rise[IX_PCI_PERR] | rise[IX_PCIX_PERR];

  always_ff @(posedge clk) begin
    if (rst) begin
      fatal_req_o    <= 1'b0;
      bus_rst_o      <= 1'b0;
      irq_o          <= 1'b0;
      fault_link_n_o <= 1'b1;
    end else begin
      fatal_req_o    <= perr_edge;
      bus_rst_o      <= perr_edge & rst_on_fatal_i;
      irq_o          <= |(grp_any & mask_q);
      fault_link_n_o <= ~(|stat.pwr);
    end
  end

endmodule

// File: rtl/err_hub_chk.sv
module err_hub_chk
  import err_hub_pkg::*;
(
  input logic             clk,
  input logic             rst,
  input logic             rd,
  input logic [7:0]       addr,
  input logic             strap,
  input logic [SRC_W-1:0] rise,
  input stat_t            stat,
  input logic [GRP_N-1:0] mask,
  input logic             fatal,
  input logic             bus_rst,
  input logic             irq,
  input logic             link_n,
  input logic             smi
);

  p_fatal_src_r1: assert property (@(posedge clk) disable iff (rst)
    fatal |-> $past(rise[IX_PCI_PERR] | rise[IX_PCIX_PERR]));

  p_fatal_follow_r1: assert property (@(posedge clk) disable iff (rst)
    (rise[IX_PCI_PERR] | rise[IX_PCIX_PERR]) |=> fatal);

  p_rst_strap_r2: assert property (@(posedge clk) disable iff (rst)
    bus_rst |-> (fatal && $past(strap)));

  p_alert_cor_r4: assert property (@(posedge clk) disable iff (rst)
    (rd && addr == A_ALERT && rise[IX_ALERT_RSR:IX_ALERT_MAIN] == 2'b00) |=> (stat.alert == 2'b00));

  p_edge_set_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(stat.pwr[0]) |-> $past(rise[IX_PSU]));

  p_irq_lvl_r7: assert property (@(posedge clk) disable iff (rst)
    irq == $past(|({|stat.riser, |stat.host, |stat.pwr, |stat.alert} & mask)));

  p_link_r8: assert property (@(posedge clk) disable iff (rst)
    link_n == !$past(|stat.pwr));

  p_smi_single_r9: assert property (@(posedge clk) disable iff (rst)
    smi |=> !smi);

endmodule

bind err_hub err_hub_chk u_chk (
  .clk(clk), .rst(rst), .rd(reg_rd_i), .addr(reg_addr_i), .strap(rst_on_fatal_i),
  .rise(rise), .stat(stat), .mask(mask_q), .fatal(fatal_req_o), .bus_rst(bus_rst_o),
  .irq(irq_o), .link_n(fault_link_n_o), .smi(smi_o)
);

// File: tb/sim_err_hub.sv
`timescale 1ns/1ps
module sim_err_hub;

  localparam int T_SMI = 40;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [10:0] src = '0;
  logic strap = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic fatal, brst, irq, link_n, smi;

  int nchk = 0, nfail = 0;
  int cyc = 0, nfat = 0, nbrst = 0, nsmi = 0, smi_cyc = 0;
  int exp_fat = 0, exp_brst = 0;
  logic [1:0] m_alert = '0;
  logic [2:0] m_pwr = '0;
  logic [3:0] m_host = '0;
  logic [1:0] m_rsr = '0;
  logic [3:0] m_mask = 4'hF;
  logic [7:0] m_ctl = 8'h01;

  always #2.5 clk = ~clk;

  err_hub #(.SMI_DELAY_CYC(T_SMI)) u0 (
    .clk(clk), .rst(rst),
    .pci_perr_i(src[0]), .pci_serr_i(src[1]), .pcix_perr_i(src[2]), .pcix_serr_i(src[3]),
    .riser_perr_i(src[4]), .riser_serr_i(src[5]), .alert_main_i(src[6]), .alert_riser_i(src[7]),
    .psu_fault_i(src[8]), .vrd_fault_i(src[9]), .thermtrip_i(src[10]), .rst_on_fatal_i(strap),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .fatal_req_o(fatal), .bus_rst_o(brst), .irq_o(irq), .fault_link_n_o(link_n), .smi_o(smi)
  );

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) if (!rst) begin
    if (fatal) nfat++;
    if (brst) nbrst++;
    if (smi) begin nsmi++; smi_cyc = cyc; end
  end

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic exp_irq();
    return (m_mask[0] & |m_alert) | (m_mask[1] & |m_pwr) |
           (m_mask[2] & |m_host) | (m_mask[3] & |m_rsr);
  endfunction

  function automatic int model_read(input logic [7:0] a);
    case (a)
      8'h10: return int'(m_alert);
      8'h11: return int'(m_pwr);
      8'h12: return int'(m_host);
      8'h13: return int'(m_mask);
      8'h14: return int'(m_ctl);
      8'h15: return int'(m_rsr);
      default: return 0;
    endcase
  endfunction

  task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk); rd = 1'b1; addr = a;
    @(posedge clk); #1 rd = 1'b0;
    @(negedge clk); d = rdata;
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(posedge clk); #1 wr = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  // model of a register read, including clear-on-read of alerts
  task automatic rd_check(input logic [7:0] a, input string req);
    logic [7:0] d;
    int e;
    e = model_read(a);
    bus_rd(a, d);
    check(req, int'(d), e);
    if (a == 8'h10) m_alert = '0;
  endtask

  task automatic wr_model(input logic [7:0] a, input logic [7:0] d);
    bus_wr(a, d);
    case (a)
      8'h11: m_pwr  = m_pwr  & ~d[2:0];
      8'h12: m_host = m_host & ~d[3:0];
      8'h13: m_mask = d[3:0];
      8'h14: m_ctl  = d;
      8'h15: m_rsr  = m_rsr  & ~d[1:0];
      default: ;
    endcase
  endtask

  task automatic pulse_src(input int ix);
    @(negedge clk); src[ix] = 1'b1;
    repeat (3) @(negedge clk);
    src[ix] = 1'b0;
    repeat (5) @(negedge clk);
    case (ix)
      0: begin m_host[0] = 1'b1; exp_fat++; if (strap) exp_brst++; end
      1: m_host[1] = 1'b1;
      2: begin m_host[2] = 1'b1; exp_fat++; if (strap) exp_brst++; end
      3: m_host[3] = 1'b1;
      4: m_rsr[0] = 1'b1;
      5: m_rsr[1] = 1'b1;
      6: m_alert[0] = 1'b1;
      7: m_alert[1] = 1'b1;
      8: m_pwr[0] = 1'b1;
      9: m_pwr[1] = 1'b1;
      default: m_pwr[2] = 1'b1;
    endcase
  endtask

  task automatic arm_smi(input logic [7:0] d, output int wcyc);
    @(negedge clk); wr = 1'b1; addr = 8'h14; wdata = d;
    @(posedge clk); #1 wr = 1'b0; wcyc = cyc;
    m_ctl = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    int w1, w2, base;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R11 reset state
    check("R11 irq reset", int'(irq), 0);
    check("R11 link reset", int'(link_n), 1);
    check("R11 smi reset", int'(smi), 0);
    rd_check(8'h11, "R11 pwr reset");
    rd_check(8'h13, "R7 mask reset");
    rd_check(8'h14, "R9 ctl reset");
    rd_check(8'h3C, "R11 unmapped read");

    // R1/R3 host parity with strap low, serr no fatal
    pulse_src(1);
    check("R1 serr no fatal", nfat, exp_fat);
    pulse_src(0);
    pulse_src(2);
    check("R1 fatal count", nfat, exp_fat);
    check("R2 strap low no reset", nbrst, 0);
    rd_check(8'h12, "R3 host status");
    wr_model(8'h12, 8'h05);
    rd_check(8'h12, "R3 host w1c");

    // R3 riser register
    pulse_src(4); pulse_src(5);
    rd_check(8'h15, "R3 riser status");
    check("R1 riser no fatal", nfat, exp_fat);
    wr_model(8'h15, 8'h03);
    wr_model(8'h12, 8'h0A);
    settle();
    check("R7 irq cleared", int'(irq), int'(exp_irq()));

    // R2 strap high
    strap = 1'b1;
    pulse_src(0);
    check("R2 reset with strap", nbrst, exp_brst);
    check("R2 fatal with strap", nfat, exp_fat);
    strap = 1'b0;
    wr_model(8'h12, 8'h0F);

    // R5/R6/R8 held power fault
    @(negedge clk); src[8] = 1'b1;
    repeat (6) @(negedge clk);
    m_pwr[0] = 1'b1;
    check("R8 link low", int'(link_n), 0);
    check("R7 irq power", int'(irq), 1);
    rd_check(8'h11, "R5 pwr status");
    wr_model(8'h11, 8'h01);
    settle();
    rd_check(8'h11, "R6 held input no re-set");
    check("R8 link released", int'(link_n), 1);
    check("R6 irq after held clear", int'(irq), 0);
    @(negedge clk); src[8] = 1'b0;
    settle();

    // R4 alert clear on read, writes ignored, same-cycle event
    pulse_src(7);
    wr_model(8'h10, 8'h00);
    rd_check(8'h10, "R4 alert readback after write");
    rd_check(8'h10, "R4 alert cleared");
    @(negedge clk); src[6] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); rd = 1'b1; addr = 8'h10;
    @(posedge clk); #1 rd = 1'b0;
    @(negedge clk); check("R4 same-cycle read old value", int'(rdata), 0);
    src[6] = 1'b0;
    m_alert = 2'b01;
    settle();
    rd_check(8'h10, "R4 same-cycle event kept");

    // R7 masks
    pulse_src(9);
    wr_model(8'h13, 8'h0D);
    settle();
    check("R7 power masked", int'(irq), 0);
    wr_model(8'h13, 8'h0F);
    settle();
    check("R7 power unmasked", int'(irq), 1);
    wr_model(8'h11, 8'h07);

    // R9 smi delay
    base = nsmi;
    arm_smi(8'h00, w1);
    repeat (T_SMI + 5) @(negedge clk);
    check("R9 smi count", nsmi - base, 1);
    check("R9 smi delay", smi_cyc - w1, T_SMI);
    rd_check(8'h14, "R9 ctl readback");
    base = nsmi;
    arm_smi(8'h01, w1);
    repeat (2 * T_SMI) @(negedge clk);
    check("R9 bit0 one no smi", nsmi - base, 0);

    // R10 restart
    base = nsmi;
    arm_smi(8'hA2, w1);
    repeat (T_SMI / 2) @(negedge clk);
    arm_smi(8'h00, w2);
    repeat (T_SMI + 5) @(negedge clk);
    check("R10 one pulse", nsmi - base, 1);
    check("R10 delay from rewrite", smi_cyc - w2, T_SMI);

    // random traffic
    for (int i = 0; i < 120; i++) begin
      int op;
      op = int'($urandom_range(0, 3));
      case (op)
        0: pulse_src(int'($urandom_range(0, 10)));
        1: rd_check(8'h10 + 8'($urandom_range(0, 5)), "R3 R4 R5 random read");
        2: wr_model(8'h10 + 8'($urandom_range(0, 5)) == 8'h14 ? 8'h13 : 8'h10 + 8'($urandom_range(0, 3)),
                    8'($urandom_range(0, 255)));
        default: wr_model(8'h13, 8'($urandom_range(0, 15)));
      endcase
      settle();
      check("R7 random irq", int'(irq), int'(exp_irq()));
      check("R8 random link", int'(link_n), int'(~|m_pwr));
    end
    check("R1 random fatal count", nfat, exp_fat);
    check("R2 random reset count", nbrst, exp_brst);

    $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

endmodule